// File: doc/BRIEF.md
# Multi-Channel Sinc3 Decimator with Selectable Ratio

This block turns one-bit delta-sigma modulator streams into signed conversion words. Every channel runs a third-order sinc (cascaded integrator-comb) low-pass filter and keeps one result out of every N modulator samples, where N is the decimation ratio. One ratio code serves all channels, so every channel finishes a conversion on the same sample and all words are published together.

The ratio set mixes powers of two with ratios that are not powers of two. A ratio that is not a power of two leaves the raw filter sum short of a full binary range. The block therefore applies a fixed gain constant for each ratio family and a shift that depends on the ratio, then clamps the result to a 24-bit word. An active-low data-ready line pulses once per published conversion.

After a start pulse or a change of the ratio code, the filter restarts from zero. The results it produces while it settles are published, not suppressed. A one-period output buffer puts the first settled word at the end of the fourth data period.

Top module: `sinc3_decimator`

## Requirements
- R1: A modulator bit of 1 counts as +1 and a bit of 0 counts as -1. For a bit pattern that repeats within N samples, the settled raw filter value is N^3 times the pattern's mean.
- R2: The ratio code maps as follows: 0:4096, 1:2048, 2:1024, 3:800, 4:768, 5:512, 6:400, 7:384, 8:256, 9:200, 10:192, 11:96, 12:64, 13:48, 14:32 and 15:32.
- R3: The word equals the raw value times a gain constant G, divided by 2^(3L-6) with round-half-up. L is the base-2 log of the smallest power of two at or above N. G is 131072 for power-of-two ratios, 130859 for 800, 400 and 200, and 131328 for 768, 384, 192, 96 and 48.
- R4: A scaled word above 8388607 becomes 8388607, and a scaled word below -8388608 becomes -8388608.
- R5: Channel c's word sits at out_data[24c+23:24c] in two's complement. All channels are updated in the same cycle.
- R6: drdy_n goes low for exactly one cycle, right after the edge that takes the sample closing a data period. It does so once per period and never falls on any other sample.
- R7: After a clear, the first data period publishes nothing. The words published after 2N and 3N samples carry unsettled results and are not gated. The word published after 4N samples is the settled value.
- R8: A start pulse, or an osr_code value that differs from the one last applied, clears all filter and counting state. The sample offered in that cycle is dropped, and no data-ready pulse follows, even when that sample would have closed a period.
- R9: After reset, drdy_n is 1 and out_data is 0. out_data holds its value between data-ready pulses.
- R10: Cycles with mod_valid low change no filter state. Idle cycles placed between samples leave both the results and the sample positions of the releases unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse (begin conversions or wake up) |
| osr_code | input | 4 | Global decimation ratio code |
| mod_valid | input | 1 | Modulator sample strobe |
| mod_bits | input | NUM_CH | One modulator bit per channel |
| out_data | output | NUM_CH*24 | Packed signed conversion words |
| drdy_n | output | 1 | Active-low data-ready pulse |

## Verification
Two things can happen in the same cycle: a restart, from a start pulse or a ratio-code change, and the modulator sample that would close a data period and trigger a release. The bench feeds 2N-1 samples, so the next sample would publish a word. It then raises start in the same cycle as that sample. The collision is judged correct when drdy_n stays high after that edge and the next release comes exactly 2N samples later, counted from the restart. A ratio change made part-way through a period is judged the same way: the first release must come 2N samples after the change, using the new N.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int MAX_LOG2  = 12;
    localparam int RATIO_W   = MAX_LOG2 + 1;
    localparam int CODE_W    = 4;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = COEF_W - 1;

    localparam logic [COEF_W-1:0] GAIN_UNITY = 18'd131072;
    localparam logic [COEF_W-1:0] GAIN_DOWN  = 18'd130859;
    localparam logic [COEF_W-1:0] GAIN_UP    = 18'd131328;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [3:0]         span_log2;
        logic [COEF_W-1:0]  gain;
    } osr_info_t;

    function automatic osr_info_t osr_lookup(input logic [CODE_W-1:0] code);
        osr_info_t r;
        case (code)
            4'd0:    r = '{ratio: 13'd4096, span_log2: 4'd12, gain: GAIN_UNITY};
            4'd1:    r = '{ratio: 13'd2048, span_log2: 4'd11, gain: GAIN_UNITY};
            4'd2:    r = '{ratio: 13'd1024, span_log2: 4'd10, gain: GAIN_UNITY};
            4'd3:    r = '{ratio: 13'd800,  span_log2: 4'd10, gain: GAIN_DOWN};
            4'd4:    r = '{ratio: 13'd768,  span_log2: 4'd10, gain: GAIN_UP};
            4'd5:    r = '{ratio: 13'd512,  span_log2: 4'd9,  gain: GAIN_UNITY};
            4'd6:    r = '{ratio: 13'd400,  span_log2: 4'd9,  gain: GAIN_DOWN};
            4'd7:    r = '{ratio: 13'd384,  span_log2: 4'd9,  gain: GAIN_UP};
            4'd8:    r = '{ratio: 13'd256,  span_log2: 4'd8,  gain: GAIN_UNITY};
            4'd9:    r = '{ratio: 13'd200,  span_log2: 4'd8,  gain: GAIN_DOWN};
            4'd10:   r = '{ratio: 13'd192,  span_log2: 4'd8,  gain: GAIN_UP};
            4'd11:   r = '{ratio: 13'd96,   span_log2: 4'd7,  gain: GAIN_UP};
            4'd12:   r = '{ratio: 13'd64,   span_log2: 4'd6,  gain: GAIN_UNITY};
            4'd13:   r = '{ratio: 13'd48,   span_log2: 4'd6,  gain: GAIN_UP};
            default: r = '{ratio: 13'd32,   span_log2: 4'd5,  gain: GAIN_UNITY};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sinc3_rate_ctrl.sv
module sinc3_rate_ctrl
    import sinc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] osr_code,
    input  logic              mod_valid,
    output logic              clr,
    output logic              take,
    output logic              tick,
    output logic              release_word,
    output osr_info_t         info
);
    localparam int CNT_W = MAX_LOG2;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
        logic              primed;
    } rate_state_t;

    rate_state_t st_d, st_q;
    logic        last_slot;

    assign info      = osr_lookup(st_q.code);
    assign last_slot = ({1'b0, st_q.cnt} == (info.ratio - RATIO_W'(1)));

    always_comb begin
        st_d         = st_q;
        clr          = start || (osr_code != st_q.code);
        take         = mod_valid && !clr;
        tick         = take && last_slot;
        release_word = tick && st_q.primed;
        if (clr) begin
            st_d.code   = osr_code;
            st_d.cnt    = '0;
            st_d.primed = 1'b0;
        end else if (take) begin
            if (last_slot) begin
                st_d.cnt    = '0;
                st_d.primed = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sinc3_channel.sv
module sinc3_channel #(
    parameter int ACC_W = 38
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    take,
    input  logic                    tick,
    input  logic                    mod_bit,
    output logic signed [ACC_W-1:0] conv
);
    typedef struct packed {
        logic signed [ACC_W-1:0] int1;
        logic signed [ACC_W-1:0] int2;
        logic signed [ACC_W-1:0] int3;
        logic signed [ACC_W-1:0] dly1;
        logic signed [ACC_W-1:0] dly2;
        logic signed [ACC_W-1:0] dly3;
        logic signed [ACC_W-1:0] res;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic signed [ACC_W-1:0] x, a1, a2, a3, c1, c2, c3;

    assign conv = st_q.res;

    always_comb begin
        st_d = st_q;
        x    = mod_bit ? ACC_W'(1) : '1;
        a1   = st_q.int1 + x;
        a2   = st_q.int2 + a1;
        a3   = st_q.int3 + a2;
        c1   = a3 - st_q.dly1;
        c2   = c1 - st_q.dly2;
        c3   = c2 - st_q.dly3;
        if (clr) begin
            st_d = '0;
        end else if (take) begin
            st_d.int1 = a1;
            st_d.int2 = a2;
            st_d.int3 = a3;
            if (tick) begin
                st_d.dly1 = a3;
                st_d.dly2 = c1;
                st_d.dly3 = c2;
                st_d.res  = c3;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sinc3_gain_sat.sv
module sinc3_gain_sat
    import sinc3_pkg::*;
#(
    parameter int ACC_W = 38,
    parameter int OUT_W = 24
) (
    input  logic signed [ACC_W-1:0] raw,
    input  logic [COEF_W-1:0]       gain,
    input  logic [3:0]              span_log2,
    output logic signed [OUT_W-1:0] word
);
    localparam int PROD_W = ACC_W + COEF_W + 1;
    localparam int TOP_W  = PROD_W - OUT_W + 1;

    logic signed [PROD_W-1:0] raw_x, gain_x, prod, half, rounded, shifted;
    logic [PROD_W-1:0]        one;
    logic [TOP_W-1:0]         top_bits;
    int                       shamt;

    always_comb begin
        raw_x    = {{(PROD_W-ACC_W){raw[ACC_W-1]}}, raw};
        gain_x   = {{(PROD_W-COEF_W){1'b0}}, gain};
        prod     = raw_x * gain_x;
        shamt    = COEF_FRAC + 3 * int'(span_log2) - (OUT_W - 1);
        one      = PROD_W'(1);
        half     = $signed(one << (shamt - 1));
        rounded  = prod + half;
        shifted  = rounded >>> shamt;
        top_bits = shifted[PROD_W-1:OUT_W-1];
        if ((&top_bits) || !(|top_bits)) begin
            word = shifted[OUT_W-1:0];
        end else if (shifted[PROD_W-1]) begin
            word = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            word = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int OUT_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [3:0]              osr_code,
    input  logic                    mod_valid,
    input  logic [NUM_CH-1:0]       mod_bits,
    output logic [NUM_CH*OUT_W-1:0] out_data,
    output logic                    drdy_n
);
    localparam int ACC_W = 3 * MAX_LOG2 + 2;

    typedef struct packed {
        logic [NUM_CH-1:0][OUT_W-1:0] words;
        logic                         rdy_n;
    } out_state_t;

    out_state_t out_d, out_q;
    logic       clr, take, tick, release_word;
    osr_info_t  info;
    logic signed [ACC_W-1:0] conv   [NUM_CH];
    logic signed [OUT_W-1:0] scaled [NUM_CH];

    sinc3_rate_ctrl u_rate (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .osr_code     (osr_code),
        .mod_valid    (mod_valid),
        .clr          (clr),
        .take         (take),
        .tick         (tick),
        .release_word (release_word),
        .info         (info)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sinc3_channel #(.ACC_W(ACC_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .take    (take),
            .tick    (tick),
            .mod_bit (mod_bits[c]),
            .conv    (conv[c])
        );
        sinc3_gain_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_scale (
            .raw       (conv[c]),
            .gain      (info.gain),
            .span_log2 (info.span_log2),
            .word      (scaled[c])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.rdy_n = !release_word;
        if (release_word) begin
            for (int c = 0; c < NUM_CH; c++) begin
                out_d.words[c] = scaled[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q       <= '0;
            out_q.rdy_n <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_data = out_q.words;
    assign drdy_n   = out_q.rdy_n;
endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk
    import sinc3_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int OUT_W  = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [3:0]              osr_code,
    input logic                    mod_valid,
    input logic [NUM_CH*OUT_W-1:0] out_data,
    input logic                    drdy_n
);
    logic [3:0]          code_q;
    logic [RATIO_W-1:0]  phase_q;
    logic [1:0]          periods_q;
    logic                restart;
    logic [RATIO_W-1:0]  n_cur;

    assign restart = start || (osr_code != code_q);
    assign n_cur   = osr_lookup(code_q).ratio;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= '0;
            phase_q   <= '0;
            periods_q <= '0;
        end else if (restart) begin
            code_q    <= osr_code;
            phase_q   <= '0;
            periods_q <= '0;
        end else if (mod_valid) begin
            if (phase_q == n_cur - RATIO_W'(1)) begin
                phase_q <= '0;
                if (periods_q != 2'd3) periods_q <= periods_q + 2'd1;
            end else begin
                phase_q <= phase_q + RATIO_W'(1);
            end
        end
    end

    AST_DRDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_n |=> drdy_n); // R6

    AST_RELEASE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_n |-> (phase_q == '0) && (periods_q >= 2'd2)); // R7

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> drdy_n); // R8

    AST_CODE_CHANGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (osr_code != code_q) |=> drdy_n); // R8

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_n |-> $stable(out_data)); // R9
endmodule

bind sinc3_decimator sinc3_decimator_chk #(.NUM_CH(NUM_CH), .OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .osr_code  (osr_code),
    .mod_valid (mod_valid),
    .out_data  (out_data),
    .drdy_n    (drdy_n)
);

// File: tb/sinc3_decimator_tb_top.sv
module sinc3_decimator_tb_top;
    localparam int NCH = 2;
    localparam int OW  = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [3:0]       osr_code = 4'd14;
    logic             mod_valid = 1'b0;
    logic [NCH-1:0]   mod_bits = '0;
    logic [NCH*OW-1:0] out_data;
    logic             drdy_n;

    int     vectors = 0;
    int     miscompares = 0;
    int     taken = 0;
    int     rel_cnt = 0;
    int     rel_at [16];
    longint rel_d0 [16];
    longint rel_d1 [16];

    always #4 clk = ~clk;

    sinc3_decimator #(.NUM_CH(NCH), .OUT_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .osr_code(osr_code),
        .mod_valid(mod_valid), .mod_bits(mod_bits), .out_data(out_data), .drdy_n(drdy_n)
    );

    function automatic int ref_ratio(input int code);
        case (code)
            0: return 4096; 1: return 2048; 2: return 1024; 3: return 800;
            4: return 768;  5: return 512;  6: return 400;  7: return 384;
            8: return 256;  9: return 200;  10: return 192; 11: return 96;
            12: return 64;  13: return 48;  default: return 32;
        endcase
    endfunction

    function automatic int ref_span(input int n);
        int l = 0;
        while ((1 << l) < n) l++;
        return l;
    endfunction

    function automatic longint ref_gain(input int n);
        if (n == 800 || n == 400 || n == 200) return 130859;
        if ((1 << ref_span(n)) == n) return 131072;
        return 131328;
    endfunction

    // settled word for a pattern with mean num/2 (num in -2..2)
    function automatic longint exp_word(input int code, input int num);
        longint n = longint'(ref_ratio(code));
        longint raw = (n * n * n * num) / 2;
        int     sh = 17 + 3 * ref_span(ref_ratio(code)) - 23;
        longint v = (raw * ref_gain(ref_ratio(code)) + (64'sd1 <<< (sh - 1))) >>> sh;
        if (v > 8388607) v = 8388607;
        if (v < -8388608) v = -8388608;
        return v;
    endfunction

    // pattern 0: all ones, 1: all zeros, 2: three ones then a zero, 3: three zeros then a one
    function automatic logic pbit(input int pat, input int i);
        case (pat)
            0: return 1'b1;
            1: return 1'b0;
            2: return (i % 4) != 0;
            default: return (i % 4) == 0;
        endcase
    endfunction

    function automatic longint word_of(input int c);
        return longint'($signed(out_data[c*OW +: OW]));
    endfunction

    task automatic check_eq(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_ne(input string req, input longint act, input longint bad);
        vectors++;
        if (act == bad) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=not %0d", req, act, bad);
        end
    endtask

    task automatic observe();
        if (!drdy_n && rel_cnt < 16) begin
            rel_at[rel_cnt] = taken;
            rel_d0[rel_cnt] = word_of(0);
            rel_d1[rel_cnt] = word_of(1);
        end
        if (!drdy_n) rel_cnt++;
    endtask

    task automatic feed(input int n, input int p0, input int p1, input bit gaps);
        for (int i = 1; i <= n + 1; i++) begin
            @(negedge clk);
            observe();
            if (i <= n) begin
                mod_valid = 1'b1;
                mod_bits  = {pbit(p1, taken + 1), pbit(p0, taken + 1)};
                taken     = taken + 1;
            end else begin
                mod_valid = 1'b0;
            end
            if (gaps && i <= n) begin
                @(negedge clk);
                observe();
                mod_valid = 1'b0;
            end
        end
        @(negedge clk);
        observe();
    endtask

    task automatic restart(input int code);
        @(negedge clk);
        osr_code  = code[3:0];
        start     = 1'b1;
        mod_valid = 1'b0;
        @(negedge clk);
        start   = 1'b0;
        taken   = 0;
        rel_cnt = 0;
    endtask

    task automatic t_reset();
        check_eq("R9 reset drdy_n", longint'(drdy_n), 1);
        check_eq("R9 reset out ch0", word_of(0), 0);
        check_eq("R9 reset out ch1", word_of(1), 0);
    endtask

    task automatic t_settling();
        restart(14);
        feed(128, 2, 3, 1'b0);
        check_eq("R6 release count in 4N", rel_cnt, 3);
        check_eq("R7 first release after 2N", rel_at[0], 64);
        check_eq("R6 second release", rel_at[1], 96);
        check_eq("R6 third release", rel_at[2], 128);
        check_ne("R7 first word unsettled", rel_d0[0], exp_word(14, 1));
        check_ne("R7 second word unsettled", rel_d0[1], exp_word(14, 1));
        check_eq("R1 R5 settled ch0", rel_d0[2], exp_word(14, 1));
        check_eq("R1 R5 settled ch1", rel_d1[2], exp_word(14, -1));
    endtask

    task automatic t_code15();
        restart(15);
        feed(128, 2, 0, 1'b0);
        check_eq("R2 code 15 first release", rel_at[0], 64);
        check_eq("R2 code 15 settled ch0", rel_d0[2], exp_word(15, 1));
    endtask

    task automatic t_round_800();
        restart(3);
        feed(3200, 0, 1, 1'b0);
        check_eq("R3 ratio 800 release", rel_at[2], 3200);
        check_eq("R3 ratio 800 round ch0", rel_d0[2], exp_word(3, 2));
        check_eq("R3 ratio 800 round ch1", rel_d1[2], exp_word(3, -2));
    endtask

    task automatic t_gaps_96();
        restart(11);
        feed(384, 2, 3, 1'b1);
        check_eq("R10 gapped release count", rel_cnt, 3);
        check_eq("R10 gapped first release", rel_at[0], 192);
        check_eq("R3 R10 ratio 96 ch0", rel_d0[2], exp_word(11, 1));
        check_eq("R3 R10 ratio 96 ch1", rel_d1[2], exp_word(11, -1));
    endtask

    task automatic t_saturate_hold();
        longint held0;
        restart(14);
        feed(128, 0, 1, 1'b0);
        check_eq("R4 positive clamp", rel_d0[2], 8388607);
        check_eq("R4 negative full scale", rel_d1[2], -8388608);
        held0 = word_of(0);
        feed(31, 2, 2, 1'b0);
        check_eq("R9 no release mid period", rel_cnt, 3);
        check_eq("R9 word held", word_of(0), held0);
        feed(1, 2, 2, 1'b0);
        check_eq("R6 release at period end", rel_at[3], 160);
    endtask

    task automatic t_4096();
        restart(0);
        feed(16384, 2, 3, 1'b0);
        check_eq("R2 ratio 4096 first release", rel_at[0], 8192);
        check_eq("R1 ratio 4096 ch0", rel_d0[2], exp_word(0, 1));
        check_eq("R1 ratio 4096 ch1", rel_d1[2], exp_word(0, -1));
    endtask

    task automatic t_start_collision();
        restart(14);
        feed(63, 2, 2, 1'b0);
        @(negedge clk);
        start     = 1'b1;
        mod_valid = 1'b1;
        mod_bits  = '1;
        @(negedge clk);
        check_eq("R8 start beats period end", longint'(drdy_n), 1);
        start     = 1'b0;
        mod_valid = 1'b0;
        taken     = 0;
        rel_cnt   = 0;
        feed(64, 2, 2, 1'b0);
        check_eq("R8 restart count after start", rel_cnt, 1);
        check_eq("R8 restart position after start", rel_at[0], 64);
    endtask

    task automatic t_code_change();
        restart(14);
        feed(50, 2, 2, 1'b0);
        @(negedge clk);
        osr_code = 4'd13;
        @(negedge clk);
        observe();
        taken   = 0;
        rel_cnt = 0;
        feed(192, 2, 3, 1'b0);
        check_eq("R8 code change first release", rel_at[0], 96);
        check_eq("R3 R8 ratio 48 ch0", rel_d0[2], exp_word(13, 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_settling();
        t_code15();
        t_round_800();
        t_gaps_96();
        t_saturate_hold();
        t_4096();
        t_start_collision();
        t_code_change();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule